// File: doc/BRIEF.md
# Capture FIFO with DMA Threshold Request

This block buffers 32-bit pixel words between an image capture packer and a bus-side reader. It holds up to 128 words in a synchronous first-in first-out store. A request line for a DMA engine rises once the number of buffered words reaches a programmable watermark. For test, the block shows its fill level, the highest fill level seen since reset, and both storage pointers.

Five conditions are tracked as sticky status bits: data present, store full, watermark reached, a write refused because the store was full, and a read refused because it was empty. Software clears a status bit by pulsing a one on its clear strobe. A per-bit mask selects which pending bits drive a single registered interrupt line. Reads are registered: the word appears on the read data port in the cycle after the read strobe.

Top module: `capture_fifo`

## Requirements
- R1: After reset, level, peak, both pointers, status, interrupt, DMA request and read data are all zero.
- R2: Accepted words are read back in write order. Read data is valid in the cycle after the read strobe and holds until the next read. The level equals accepted writes minus accepted reads, and a write and a read in the same cycle leave the level unchanged.
- R3: A write while the level is 128 is dropped, even when a read arrives in the same cycle. The level and the write pointer do not move, and status bit 3 (overflow) sets at that edge.
- R4: A read while the level is 0 puts zero on the read data port. The read pointer does not move, and status bit 4 (underflow) sets at that edge.
- R5: Each pointer advances by one per accepted access and wraps from 127 to 0.
- R6: The watermark is the 7-bit configuration value plus one (1 to 128). With DMA enabled, the request is high in any cycle in which the level is at or above the watermark, without a register stage.
- R7: With DMA disabled the request is low, whatever the level.
- R8: The peak output holds the largest level reached since reset and never falls.
- R9: Status bit 0 (non-empty, level > 0), bit 1 (full, level = 128) and bit 2 (watermark reached, level >= watermark) are sampled from the level each cycle and set at the next edge.
- R10: A one on a clear-strobe bit clears that status bit, and a zero leaves it alone. If the bit's event occurs in the same cycle as its clear, the bit stays set.
- R11: The interrupt is a register loaded each cycle with the OR over all bits of (status AND mask). A masked pending bit does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the packer |
| wr_data | input | 32 | Word to store |
| rd_en | input | 1 | Read strobe from the bus reader |
| rd_data | output | 32 | Registered read word |
| dma_en | input | 1 | Enables the DMA request |
| thr_cfg | input | 7 | Watermark minus one |
| dma_req | output | 1 | DMA request |
| level | output | 8 | Current fill level, 0 to 128 |
| peak | output | 8 | Highest level since reset |
| wr_ptr | output | 7 | Write pointer |
| rd_ptr | output | 7 | Read pointer |
| evt_mask | input | 5 | Per-bit interrupt enable |
| sts_clr | input | 5 | Write-one-to-clear strobes for the status bits |
| status | output | 5 | Sticky event bits (0 non-empty, 1 full, 2 watermark, 3 overflow, 4 underflow) |
| irq | output | 1 | Registered interrupt |

## Verification
The bench fills the store to exactly 128 words and then writes once more. A design that accepted that write would corrupt the oldest word or move the level past 128. The watermark is probed at one word below and at the watermark, with configuration values 3 and 127. A design that dropped the plus-one encoding would raise the request one word early. A clear that lands in the same cycle as a fresh underflow must leave the bit set; a design that ranked the clear first would lose the event. The bench also reads from an empty store, where a design that moved its read pointer would later return stale words out of order.

// File: rtl/cap_fifo_pkg.sv
package cap_fifo_pkg;
  localparam int EV_NUM       = 5;
  localparam int EV_NONEMPTY  = 0;
  localparam int EV_FULL      = 1;
  localparam int EV_THRESH    = 2;
  localparam int EV_OVERFLOW  = 3;
  localparam int EV_UNDERFLOW = 4;
endpackage

// File: rtl/cap_fifo_store.sv
module cap_fifo_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic [LVL_W-1:0]  level,
  output logic [LVL_W-1:0]  peak,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_acc, rd_acc;
  logic [PTR_W-1:0]  wr_ptr_n, rd_ptr_n;
  logic [LVL_W-1:0]  level_n, peak_n;
  logic [DATA_W-1:0] rd_data_n;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);

  always_comb begin
    wr_acc    = wr_en && !full;
    rd_acc    = rd_en && !empty;
    wr_ptr_n  = wr_acc ? ptr_step(wr_ptr) : wr_ptr;
    rd_ptr_n  = rd_acc ? ptr_step(rd_ptr) : rd_ptr;
    level_n   = level;
    case ({wr_acc, rd_acc})
      2'b10:   level_n = level + 1'b1;
      2'b01:   level_n = level - 1'b1;
      default: level_n = level;
    endcase
    peak_n    = (level_n > peak) ? level_n : peak;
    rd_data_n = rd_data;
    if (rd_acc)     rd_data_n = mem[rd_ptr];
    else if (rd_en) rd_data_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level   <= '0;
      peak    <= '0;
      rd_data <= '0;
    end else begin
      wr_ptr  <= wr_ptr_n;
      rd_ptr  <= rd_ptr_n;
      level   <= level_n;
      peak    <= peak_n;
      rd_data <= rd_data_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_acc) mem[wr_ptr] <= wr_data;
  end

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));
  assert_full_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> ($stable(wr_ptr) && $stable(level)));
  assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty) |=> ((rd_data == '0) && $stable(rd_ptr)));
  assert_peak_covers_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    peak >= level);
endmodule

// File: rtl/cap_fifo_dma.sv
module cap_fifo_dma #(
  parameter int LVL_W = 8,
  parameter int THR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [THR_W-1:0] thr_cfg,
  input  logic             dma_en,
  output logic             thr_hit,
  output logic             dma_req
);
  logic [LVL_W-1:0] watermark;

  always_comb begin
    watermark = LVL_W'(thr_cfg) + 1'b1;
    thr_hit   = (level >= watermark);
    dma_req   = dma_en && thr_hit;
  end

  assert_dma_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !dma_req);
  assert_below_mark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= LVL_W'(thr_cfg)) |-> !dma_req);
endmodule

// File: rtl/cap_fifo_events.sv
module cap_fifo_events #(
  parameter int EV_NUM = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EV_NUM-1:0] ev,
  input  logic [EV_NUM-1:0] clr,
  input  logic [EV_NUM-1:0] mask,
  output logic [EV_NUM-1:0] status,
  output logic              irq
);
  logic [EV_NUM-1:0] status_n;
  logic              irq_n;

  always_comb begin
    status_n = (status & ~clr) | ev;
    irq_n    = |(status & mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_n;
      irq    <= irq_n;
    end
  end

  for (genvar i = 0; i < EV_NUM; i++) begin : g_bit
    assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> status[i]);
    assert_clear_takes_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !ev[i]) |=> !status[i]);
  end

  assert_irq_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(status & mask)) |=> !irq);
endmodule

// File: rtl/capture_fifo.sv
module capture_fifo
  import cap_fifo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              dma_en,
  input  logic [PTR_W-1:0]  thr_cfg,
  output logic              dma_req,
  output logic [LVL_W-1:0]  level,
  output logic [LVL_W-1:0]  peak,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [PTR_W-1:0]  rd_ptr,
  input  logic [EV_NUM-1:0] evt_mask,
  input  logic [EV_NUM-1:0] sts_clr,
  output logic [EV_NUM-1:0] status,
  output logic              irq
);
  logic              full, empty, thr_hit;
  logic [EV_NUM-1:0] ev;

  cap_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .level(level), .peak(peak), .full(full), .empty(empty)
  );

  cap_fifo_dma #(.LVL_W(LVL_W), .THR_W(PTR_W)) u_dma (
    .clk(clk), .rst_n(rst_n), .level(level), .thr_cfg(thr_cfg),
    .dma_en(dma_en), .thr_hit(thr_hit), .dma_req(dma_req)
  );

  always_comb begin
    ev               = '0;
    ev[EV_NONEMPTY]  = !empty;
    ev[EV_FULL]      = full;
    ev[EV_THRESH]    = thr_hit;
    ev[EV_OVERFLOW]  = wr_en && full;
    ev[EV_UNDERFLOW] = rd_en && empty;
  end

  cap_fifo_events #(.EV_NUM(EV_NUM)) u_events (
    .clk(clk), .rst_n(rst_n), .ev(ev), .clr(sts_clr), .mask(evt_mask),
    .status(status), .irq(irq)
  );
endmodule

// File: tb/tb_capture_fifo.sv
module tb_capture_fifo;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en, dma_en, dma_req, irq;
  logic [31:0] wr_data, rd_data;
  logic [6:0]  thr_cfg, wr_ptr, rd_ptr;
  logic [7:0]  level, peak;
  logic [4:0]  evt_mask, sts_clr, status;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  capture_fifo dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .dma_en(dma_en), .thr_cfg(thr_cfg),
    .dma_req(dma_req), .level(level), .peak(peak), .wr_ptr(wr_ptr),
    .rd_ptr(rd_ptr), .evt_mask(evt_mask), .sts_clr(sts_clr),
    .status(status), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [31:0] wd;
    logic [7:0]  lvl;
    logic [31:0] rdat;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b1, 1'b0, 32'hA0A0_0001, 8'd1, 32'h0},
    '{1'b1, 1'b0, 32'hA0A0_0002, 8'd2, 32'h0},
    '{1'b1, 1'b0, 32'hA0A0_0003, 8'd3, 32'h0},
    '{1'b0, 1'b1, 32'h0,         8'd2, 32'hA0A0_0001},
    '{1'b1, 1'b1, 32'hA0A0_0004, 8'd2, 32'hA0A0_0002},
    '{1'b0, 1'b1, 32'h0,         8'd1, 32'hA0A0_0003},
    '{1'b0, 1'b1, 32'h0,         8'd0, 32'hA0A0_0004},
    '{1'b0, 1'b1, 32'h0,         8'd0, 32'h0}
  };

  localparam logic [31:0] BASE = 32'hC0DE_0000;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [31:0] d, input logic [4:0] c);
    wr_en = w; rd_en = r; wr_data = d; sts_clr = c;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; sts_clr = '0;
  endtask

  initial begin
    #(20000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    dma_en = 1'b0; thr_cfg = 7'd3; evt_mask = '0; sts_clr = '0;
    repeat (3) @(negedge clk);
    chk("R1 level", 32'(level), 32'd0);
    chk("R1 peak", 32'(peak), 32'd0);
    chk("R1 ptrs", {wr_ptr, rd_ptr}, 32'd0);
    chk("R1 status", 32'(status), 32'd0);
    chk("R1 irq/dma", {irq, dma_req}, 32'd0);
    chk("R1 rd_data", rd_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R4: table of ordered writes/reads, ending with a read from empty
    foreach (TBL[i]) begin
      step(TBL[i].wr, TBL[i].rd, TBL[i].wd, '0);
      chk($sformatf("R2 level row %0d", i), 32'(level), 32'(TBL[i].lvl));
      chk($sformatf("R2 R4 rd_data row %0d", i), rd_data, TBL[i].rdat);
    end
    chk("R4 rd_ptr unmoved by empty read", 32'(rd_ptr), 32'd4);
    chk("R5 wr_ptr", 32'(wr_ptr), 32'd4);
    chk("R8 peak after table", 32'(peak), 32'd3);
    chk("R9 R4 status non-empty+underflow", 32'(status), 32'h11);
    chk("R11 masked pending gives no irq", 32'(irq), 32'd0);

    // R10: zero bits leave status alone, one bits clear it
    step(1'b0, 1'b0, '0, 5'h01);
    chk("R10 partial clear", 32'(status), 32'h10);
    step(1'b0, 1'b0, '0, 5'h10);
    chk("R10 full clear", 32'(status), 32'h00);
    step(1'b0, 1'b1, '0, 5'h10);
    chk("R10 event beats clear", 32'(status), 32'h10);

    // R11: mask opens, irq follows one cycle later
    evt_mask = 5'h10;
    step(1'b0, 1'b0, '0, '0);
    chk("R11 irq raised", 32'(irq), 32'd1);
    evt_mask = 5'h00;
    step(1'b0, 1'b0, '0, '0);
    chk("R11 irq dropped when masked", 32'(irq), 32'd0);
    step(1'b0, 1'b0, '0, 5'h10);

    // R6 R7: watermark 4 (cfg 3)
    dma_en = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, BASE + 32'(i), '0);
    chk("R6 below watermark", 32'(dma_req), 32'd0);
    step(1'b1, 1'b0, BASE + 32'd3, '0);
    chk("R6 at watermark", 32'(dma_req), 32'd1);
    step(1'b0, 1'b0, '0, '0);
    chk("R9 status non-empty+watermark", 32'(status), 32'h05);
    dma_en = 1'b0;
    #1;
    chk("R7 dma disabled", 32'(dma_req), 32'd0);

    // R6 R5 R3: watermark 128 (cfg 127), fill to full
    thr_cfg = 7'd127;
    dma_en  = 1'b1;
    for (int i = 4; i < 127; i++) begin
      step(1'b1, 1'b0, BASE + 32'(i), '0);
      if (i == 123) chk("R5 wr_ptr wraps to 0", 32'(wr_ptr), 32'd0);
    end
    chk("R6 level 127 below 128 mark", {24'd0, level[6:0], dma_req}, {24'd0, 7'd127, 1'b0});
    step(1'b1, 1'b0, BASE + 32'd127, '0);
    chk("R6 at 128 mark", 32'(dma_req), 32'd1);
    chk("R2 level full", 32'(level), 32'd128);
    step(1'b0, 1'b0, '0, '0);
    chk("R9 full status", 32'(status), 32'h07);
    step(1'b1, 1'b1, 32'hDEAD_BEEF, '0);
    chk("R3 level after read+dropped write", 32'(level), 32'd127);
    chk("R3 overflow on write with read", 32'(status[3]), 32'd1);
    chk("R2 first word out", rd_data, BASE);
    step(1'b1, 1'b0, BASE + 32'd128, '0);
    chk("R2 refill to 128", 32'(level), 32'd128);
    step(1'b1, 1'b0, 32'hDEAD_BEEF, '0);
    chk("R3 level held", 32'(level), 32'd128);
    chk("R3 wr_ptr held", 32'(wr_ptr), 32'd5);
    chk("R8 peak 128", 32'(peak), 32'd128);
    dma_en = 1'b0;

    for (int i = 1; i <= 128; i++) begin
      step(1'b0, 1'b1, '0, '0);
      chk($sformatf("R2 drain word %0d", i), rd_data, BASE + 32'(i));
    end
    chk("R2 drained", 32'(level), 32'd0);
    chk("R5 rd_ptr wrapped", 32'(rd_ptr), 32'd5);
    chk("R8 peak holds", 32'(peak), 32'd128);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule